// File: doc/BRIEF.md
# Multi-lane SPI frame sequencer

This block is the serial engine of a host-side quad SPI controller. It runs one framed transaction at a time. A frame is described by three counts: the total number of bytes, the number of leading command bytes, and an optional number of idle clocks placed between the command bytes and the bytes that follow them. The engine generates the serial clock and the active-low chip select, and it drives or releases four data lanes. It fetches outgoing bytes from a first-word-fall-through transmit queue and hands received bytes to a receive queue.

Each byte's lane width comes from a two-bit lane mode and a dual/quad width bit. Command bytes and the address bytes that follow them can stay on one lane while the data that follows moves on two or four lanes. Full mode puts everything on the wide lanes. The surrounding register file, the queues and the flash device sit outside this block. The queues are assumed never to run empty or full while a frame is running.

Top module: `qspi_frame_seq`

## Requirements
- R1: `ready` is 1 exactly when no frame is running. A `start` pulse begins a frame only when `ready` is 1 and the total count is non-zero. Otherwise `start` changes nothing. When the last bit has been clocked, `cs_n` returns high, `ready` rises and `done` is 1 for exactly one clock.
- R2: In the first clock after an accepted `start`, `cs_n` goes low. `sclk` then stays at its idle level for H clocks, where H = `cfg_rate`, or 1 when `cfg_rate` is 0. After that, each serial clock cycle is H clocks with `sclk` low followed by H clocks with `sclk` high.
- R3: While idle, `sclk` rests at `cfg_clk_idle` (0 low, 1 high). Outgoing bits change at the start of each low half-period. Incoming lanes are sampled when `sclk` rises.
- R4: The total count is `{cfg_total_hi, cfg_total_lo}`. Bytes with an index below the command count are transmitted, and nothing is pushed for them. Every later byte is pushed to `rx_data` with a one-clock `rx_push` after its last bit. A command count of at least the total count makes the frame transmit-only.
- R5: Lane mode 0 (normal): every byte takes 8 cycles, MSB first, out on DQ0 (`dq_oe` = 0001). It is sampled from DQ1, and every byte pops the transmit queue (full duplex).
- R6: Lane mode 1: command bytes use DQ0 alone. Every later byte is received on the wide lanes with `dq_oe` = 0000 and no transmit pop. A transmit-only frame therefore never leaves DQ0.
- R7: Lane mode 2: byte 0 uses DQ0 alone. The other command bytes are driven on the wide lanes, and later bytes are received on the wide lanes.
- R8: Lane mode 3: every command byte is driven on the wide lanes, and every later byte is received on them.
- R9: With `cfg_quad` = 0, the wide lanes are DQ1..DQ0, with DQ1 carrying the more significant bit of each pair, and a byte takes 4 cycles (`dq_oe` = 0011 when driven). With `cfg_quad` = 1, they are DQ3..DQ0, high nibble first with DQ3 as its MSB, and a byte takes 2 cycles (`dq_oe` = 1111 when driven). `dq_oe` only ever takes the values 0000, 0001, 0011 and 1111.
- R10: When the command count is non-zero, bytes follow the command bytes, and `cfg_idle_cycles` N is non-zero, N serial clock cycles with every lane released are inserted after the last command byte. When N is 0, no cycles are inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame with the present configuration |
| cfg_total_lo | input | 16 | Total byte count, low half |
| cfg_total_hi | input | 16 | Total byte count, high half |
| cfg_cmd_bytes | input | CMD_W | Number of leading command bytes |
| cfg_idle_cycles | input | IDLE_W | Idle serial cycles after the command bytes |
| cfg_lane_mode | input | 2 | 0 normal, 1 wide reads, 2 wide after first byte, 3 all wide |
| cfg_quad | input | 1 | Wide lanes: 0 two lanes, 1 four lanes |
| cfg_rate | input | RATE_W | Half-period of the serial clock in system clocks |
| cfg_clk_idle | input | 1 | Serial clock idle level |
| tx_data | input | 8 | Head of the transmit queue |
| tx_pop | output | 1 | Consume the head of the transmit queue |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | `rx_data` is valid for one clock |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dq_out | output | 4 | Lane output values |
| dq_oe | output | 4 | Lane output enables |
| dq_in | input | 4 | Lane input values |
| ready | output | 1 | No frame running |
| done | output | 1 | One-clock pulse at the end of a frame |

## Verification
Frames are run in every lane mode, with both dual and quad widths. Command and total counts are chosen to produce a full-duplex frame, a transmit-only frame, a command count above the total, and split frames with and without idle clocks. These separate the per-byte lane choice, the phase boundaries and the idle insertion. Rates 0, 1, 2 and 3 and both idle levels separate the half-period timing from the clock polarity. The lanes change value every system clock, so any error in the sampling instant or in the lane order shows up in the received bytes. A `start` during a frame and a zero-length `start` confirm that neither disturbs the lanes or the status.

// File: rtl/qspi_frame_seq.sv
module qspi_frame_seq #(
  parameter int CMD_W  = 9,
  parameter int IDLE_W = 4,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       cfg_total_lo,
  input  logic [15:0]       cfg_total_hi,
  input  logic [CMD_W-1:0]  cfg_cmd_bytes,
  input  logic [IDLE_W-1:0] cfg_idle_cycles,
  input  logic [1:0]        cfg_lane_mode,
  input  logic              cfg_quad,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_clk_idle,
  input  logic [7:0]        tx_data,
  output logic              tx_pop,
  output logic [7:0]        rx_data,
  output logic              rx_push,
  output logic              sclk,
  output logic              cs_n,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe,
  input  logic [3:0]        dq_in,
  output logic              ready,
  output logic              done
);
  localparam int LEFT_W = (IDLE_W > 4) ? IDLE_W : 4;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SHIFT} st_t;

  st_t               st;
  logic [31:0]       tot_q, cmd_q, idx;
  logic [IDLE_W-1:0] idle_q;
  logic [1:0]        mode_q, lw;
  logic              quad_q, lvl_q, hi, gap, recv_q;
  logic [RATE_W-1:0] rate_q, cnt;
  logic [LEFT_W-1:0] left;
  logic [7:0]        sh, rxsh;
  logic [3:0]        oe_q;

  wire [31:0] total_in = {cfg_total_hi, cfg_total_lo};
  wire [31:0] cmd_in   = 32'(cfg_cmd_bytes);
  wire        tick     = (cnt == rate_q - 1'b1);
  wire [31:0] nxt      = (st == S_SETUP || gap) ? idx : idx + 32'd1;
  wire        last     = !gap && (idx + 32'd1 == tot_q);
  wire        to_gap   = !gap && (nxt == cmd_q) && (cmd_q != 0) && (cmd_q < tot_q) && (idle_q != 0);
  wire        in_cmd   = nxt < cmd_q;
  wire [1:0]  wm       = quad_q ? 2'd2 : 2'd1;

  logic [1:0]        n_lw;
  logic              n_drv;
  logic [3:0]        n_oe;
  logic [LEFT_W-1:0] n_left;

  always_comb begin
    n_drv = in_cmd;
    case (mode_q)
      2'd0:    begin n_lw = 2'd0; n_drv = 1'b1; end
      2'd1:    n_lw = in_cmd ? 2'd0 : wm;
      2'd2:    n_lw = (in_cmd && nxt == 0) ? 2'd0 : wm;
      default: n_lw = wm;
    endcase
    case (n_lw)
      2'd0:    begin n_oe = 4'b0001; n_left = LEFT_W'(8); end
      2'd1:    begin n_oe = 4'b0011; n_left = LEFT_W'(4); end
      default: begin n_oe = 4'b1111; n_left = LEFT_W'(2); end
    endcase
    if (!n_drv) n_oe = 4'b0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tot_q <= '0; cmd_q <= '0; idx <= '0; idle_q <= '0;
      mode_q <= '0; quad_q <= 1'b0; lvl_q <= 1'b0; rate_q <= RATE_W'(1);
      cnt <= '0; hi <= 1'b0; gap <= 1'b0; recv_q <= 1'b0; lw <= '0;
      left <= '0; sh <= '0; rxsh <= '0; oe_q <= '0;
      tx_pop <= 1'b0; rx_push <= 1'b0; rx_data <= '0; done <= 1'b0;
    end else begin
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      done    <= 1'b0;
      case (st)
        S_IDLE: if (start && total_in != 0) begin
          st     <= S_SETUP;
          tot_q  <= total_in;
          cmd_q  <= (cmd_in >= total_in) ? total_in : cmd_in;
          idle_q <= cfg_idle_cycles;
          mode_q <= cfg_lane_mode;
          quad_q <= cfg_quad;
          rate_q <= (cfg_rate == 0) ? RATE_W'(1) : cfg_rate;
          lvl_q  <= cfg_clk_idle;
          idx    <= '0;
          cnt    <= '0;
          gap    <= 1'b0;
        end
        default: if (!tick) cnt <= cnt + 1'b1;
        else begin
          cnt <= '0;
          hi  <= (st == S_SHIFT) ? !hi : 1'b0;
          if (st == S_SHIFT && !hi) begin
            case (lw)
              2'd0:    rxsh <= {rxsh[6:0], dq_in[1]};
              2'd1:    rxsh <= {rxsh[5:0], dq_in[1:0]};
              default: rxsh <= {rxsh[3:0], dq_in};
            endcase
          end
          if (st == S_SHIFT && hi) begin
            sh   <= sh << (1 << lw);
            left <= left - 1'b1;
            if (left == 1 && recv_q && !gap) begin
              rx_push <= 1'b1;
              rx_data <= rxsh;
            end
          end
          if (st == S_SETUP || (hi && left == 1)) begin
            if (st == S_SHIFT && last) begin
              st   <= S_IDLE;
              done <= 1'b1;
              oe_q <= '0;
            end else if (st == S_SHIFT && to_gap) begin
              gap    <= 1'b1;
              idx    <= nxt;
              left   <= LEFT_W'(idle_q);
              oe_q   <= '0;
              sh     <= '0;
              recv_q <= 1'b0;
            end else begin
              st     <= S_SHIFT;
              gap    <= 1'b0;
              idx    <= nxt;
              lw     <= n_lw;
              oe_q   <= n_oe;
              recv_q <= !in_cmd;
              left   <= n_left;
              sh     <= n_drv ? tx_data : 8'h00;
              tx_pop <= n_drv;
            end
          end
        end
      endcase
    end
  end

  assign ready = (st == S_IDLE);
  assign cs_n  = (st == S_IDLE);
  assign sclk  = (st == S_SHIFT) ? hi : (st == S_IDLE ? cfg_clk_idle : lvl_q);
  assign dq_oe = (st == S_SHIFT) ? oe_q : 4'b0000;

  always_comb begin
    case (lw)
      2'd0:    dq_out = {3'b000, sh[7]};
      2'd1:    dq_out = {2'b00, sh[7:6]};
      default: dq_out = sh[7:4];
    endcase
  end
endmodule

// File: rtl/qspi_frame_seq_chk.sv
module qspi_frame_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ready,
  input logic       done,
  input logic       tx_pop,
  input logic       rx_push,
  input logic [3:0] dq_oe,
  input logic [1:0] cfg_lane_mode
);
  assert_oe_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'b0000 || dq_oe == 4'b0001 || dq_oe == 4'b0011 || dq_oe == 4'b1111));

  assert_drive_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 4'b0000) |-> !cs_n);

  assert_done_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_normal_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cfg_lane_mode == 2'd0) |-> (dq_oe[3:1] == 3'b000));

  assert_pop_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !cs_n);

  assert_push_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !$past(ready));
endmodule

bind qspi_frame_seq qspi_frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ready(ready), .done(done),
  .tx_pop(tx_pop), .rx_push(rx_push), .dq_oe(dq_oe), .cfg_lane_mode(cfg_lane_mode)
);

// File: tb/sim_qspi_frame_seq.sv
module sim_qspi_frame_seq;
  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] cfg_total_lo = '0, cfg_total_hi = '0;
  logic [8:0] cfg_cmd_bytes = '0;
  logic [3:0] cfg_idle_cycles = '0, cfg_rate = 4'd1, dq_in = '0;
  logic [1:0] cfg_lane_mode = '0;
  logic       cfg_quad = 1'b0, cfg_clk_idle = 1'b0;
  logic [7:0] tx_data = '0, rx_data;
  logic       tx_pop, rx_push, sclk, cs_n, ready, done;
  logic [3:0] dq_out, dq_oe;

  always #2 clk = ~clk;

  qspi_frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_total_lo(cfg_total_lo),
    .cfg_total_hi(cfg_total_hi), .cfg_cmd_bytes(cfg_cmd_bytes),
    .cfg_idle_cycles(cfg_idle_cycles), .cfg_lane_mode(cfg_lane_mode),
    .cfg_quad(cfg_quad), .cfg_rate(cfg_rate), .cfg_clk_idle(cfg_clk_idle),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
    .sclk(sclk), .cs_n(cs_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
    .ready(ready), .done(done)
  );

  typedef struct {
    logic cs_n, sclk, ready, done, pop, push;
    logic [3:0] oe, dq;
    int smp, req;
  } rec_t;

  rec_t       exp_q[$];
  logic [7:0] txq[$];
  logic [7:0] mshift = '0;
  bit         pend = 1'b0;
  int         compared = 0, mismatched = 0, seed = 1;

  task automatic addrec(logic c, logic s, logic rd, logic dn, logic pp,
                        logic [3:0] oe, logic [3:0] dq, int smp, int req);
    rec_t r;
    r.cs_n = c; r.sclk = s; r.ready = rd; r.done = dn; r.pop = pp;
    r.push = pend; pend = 1'b0;
    r.oe = oe; r.dq = dq; r.smp = smp; r.req = req;
    exp_q.push_back(r);
  endtask

  // Expected per-clock trace of one frame, derived from the requirements.
  task automatic build(int total, int cmd, int idle, int mode, bit quad, int rate, bit lvl);
    int c  = (cmd >= total) ? total : cmd;
    int h  = (rate == 0) ? 1 : rate;
    int wm = quad ? 4 : 2;
    for (int i = 0; i < h; i++) addrec(0, lvl, 0, 0, 0, 0, 0, 0, 2);
    for (int b = 0; b < total; b++) begin
      int w, mask, req;
      bit drv, rcv;
      logic [7:0] v;
      if (b == c && c > 0 && c < total && idle > 0)
        for (int k = 0; k < idle; k++) begin
          for (int i = 0; i < h; i++) addrec(0, 0, 0, 0, 0, 0, 0, 0, 10);
          for (int i = 0; i < h; i++) addrec(0, 1, 0, 0, 0, 0, 0, 0, 10);
        end
      rcv = (b >= c);
      drv = !rcv;
      case (mode)
        0: begin w = 1; drv = 1'b1; end
        1: w = rcv ? wm : 1;
        2: w = (b == 0 && !rcv) ? 1 : wm;
        default: w = wm;
      endcase
      req = 5 + mode;
      mask = (1 << w) - 1;
      v = 8'h00;
      if (drv) begin
        v = 8'(seed * 37 + 11);
        seed++;
        txq.push_back(v);
      end
      for (int k = 0; k < 8 / w; k++) begin
        logic [3:0] ch = 4'((int'(v) >> (8 - w * (k + 1))) & mask);
        logic [3:0] oe = drv ? 4'(mask) : 4'b0000;
        for (int i = 0; i < h; i++) addrec(0, 0, 0, 0, drv && k == 0 && i == 0, oe, ch, 0, req);
        for (int i = 0; i < h; i++) addrec(0, 1, 0, 0, 0, oe, ch, (i == 0) ? w : 0, req);
      end
      pend = rcv;
    end
    addrec(1, lvl, 1, 1, 0, 0, 0, 0, 1);
  endtask

  task automatic monitor();
    forever begin
      rec_t e;
      bit ok;
      @(negedge clk);
      if (rst_n) begin
        if (exp_q.size() != 0) e = exp_q.pop_front();
        else begin
          e.cs_n = 1; e.sclk = cfg_clk_idle; e.ready = 1; e.done = 0; e.pop = 0;
          e.push = 0; e.oe = 0; e.dq = 0; e.smp = 0; e.req = 1;
        end
        if (e.smp == 1) mshift = {mshift[6:0], dq_in[1]};
        else if (e.smp == 2) mshift = {mshift[5:0], dq_in[1:0]};
        else if (e.smp == 4) mshift = {mshift[3:0], dq_in};
        compared++;
        ok = cs_n == e.cs_n && sclk == e.sclk && ready == e.ready && done == e.done &&
             dq_oe == e.oe && (dq_out & dq_oe) == (e.dq & e.oe) && tx_pop == e.pop &&
             rx_push == e.push && (!e.push || rx_data == mshift);
        if (!ok) begin
          mismatched++;
          $display("FAIL R%0d t=%0t got cs=%b sclk=%b rdy=%b done=%b oe=%h dq=%h pop=%b push=%b rx=%h exp cs=%b sclk=%b rdy=%b done=%b oe=%h dq=%h pop=%b push=%b rx=%h",
                   e.req, $time, cs_n, sclk, ready, done, dq_oe, dq_out & dq_oe, tx_pop, rx_push, rx_data,
                   e.cs_n, e.sclk, e.ready, e.done, e.oe, e.dq & e.oe, e.pop, e.push, mshift);
        end
        if (tx_pop && txq.size() != 0) void'(txq.pop_front());
        tx_data = (txq.size() != 0) ? txq[0] : 8'h00;
        dq_in = dq_in * 4'd5 + 4'd3;
      end
    end
  endtask

  task automatic watchdog();
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog expired got busy expected idle");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic frame(int total, int cmd, int idle, int mode, bit quad, int rate, bit lvl, bit poke);
    @(negedge clk); #1;
    cfg_total_lo = 16'(total); cfg_total_hi = 16'(total >> 16);
    cfg_cmd_bytes = 9'(cmd); cfg_idle_cycles = 4'(idle); cfg_lane_mode = 2'(mode);
    cfg_quad = quad; cfg_rate = 4'(rate); cfg_clk_idle = lvl;
    if (total != 0) build(total, cmd, idle, mode, quad, rate, lvl);
    start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      #1 start = 1'b1;            // R1: start while busy is ignored
      @(negedge clk); #1 start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      monitor();
      watchdog();
    join_none
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;                 // R1: reset state compared from here
    repeat (3) @(negedge clk);
    frame(3, 1, 0, 0, 0, 2, 0, 0);   // R5 R4 normal, split frame
    frame(2, 0, 0, 0, 0, 1, 1, 0);   // R5 R3 full duplex, idle high
    frame(2, 2, 3, 0, 0, 3, 0, 1);   // R4 transmit only, R1 start while busy
    frame(2, 5, 0, 0, 0, 1, 0, 0);   // R4 command count above total
    frame(5, 4, 3, 1, 1, 1, 0, 0);   // R6 R9 R10 quad read with idle cycles
    frame(4, 1, 0, 1, 0, 2, 1, 0);   // R6 R9 dual read, no idle
    frame(3, 3, 2, 1, 1, 1, 0, 0);   // R6 transmit-only stays on DQ0
    frame(6, 4, 2, 2, 1, 1, 0, 0);   // R7 R10 first byte single then quad
    frame(3, 3, 0, 2, 0, 2, 0, 0);   // R7 dual write
    frame(4, 2, 1, 3, 1, 0, 1, 0);   // R8 R2 full quad, rate 0 acts as 1
    frame(2, 0, 0, 3, 0, 1, 0, 0);   // R8 dual, all bytes received
    frame(0, 0, 0, 0, 0, 1, 0, 0);   // R1 zero-length start ignored
    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule